// File: doc/BRIEF.md
# Virtualized Supervisor Interrupt View

This block sits between the CSR access path of a hart and its shared 64-bit machine-level interrupt enable and pending arrays. It serves read-modify-write accesses made through the supervisor, guest (VS) and hypervisor views of those arrays. Each view may reach only its own subset of bits. The block holds the hypervisor delegation register, which decides which guest interrupts a guest may see or change. For every access it works out which bits may change and where they sit in the 64-bit machine layout. It then forwards one masked request to the machine storage and turns the old value that the storage returns back into the numbering of the view.

Each view has a low-half form and a high-half form. The high-half form moves the request to bits 63:32 and returns bits 63:32, so that a 32-bit hart can reach all 64 interrupt lines. When the virtualization-mode input is set, a guest sees its own interrupts at the supervisor bit positions. On writes the block lifts those bits one place up into the guest slots, and on reads it moves them back down. Accesses that fail the legality rules are refused as illegal and forward nothing.

The storage sits outside the block. The forwarded request and the remapping are combinational, so the storage sees the request in the same cycle. The response is registered one cycle later.

Top module: `vsi_intr_view`

## Requirements
- R1: While `rst` is high, the next cycle shows `rsp_valid`=0, `rsp_illegal`=0 and `rsp_rdata`=0. The held delegation register is cleared to zero.
- R2: View codes are 0 supervisor enable, 1 supervisor pending, 2 guest enable, 3 guest pending, 4 hypervisor delegation, 5 hypervisor virtual pending and 6 hypervisor enable. `m_sel` is 0 for the enable array and 1 for the pending array. Every accepted request gives `rsp_valid`=1 in the following cycle. A cycle with no request gives `rsp_valid`=0 in the next cycle.
- R3: Guest enable view: bits 1, 5 and 9 of the data and of the mask are cleared and set again at bits 2, 6 and 10, and all other bits are kept. The forwarded mask is limited to bits {2,6,10} that are also set in the delegation register. The returned value is the old value ANDed with that same set, with bits 2, 6 and 10 moved down to 1, 5 and 9.
- R4: Guest pending view: as in R3, but the set used both for the write mask and for the read filter is the delegation register ANDed with bit 2 only. The request goes to the pending array.
- R5: With `virt_mode`=1, supervisor enable and supervisor pending accesses take the guest path of R3 or R4. The returned value is further ANDed with `m_deleg` and with the set {1,5,9}.
- R6: With `virt_mode`=0, a supervisor enable write mask is limited to `m_deleg` AND {1,5,9}. A supervisor pending write mask is limited to `m_deleg` AND {1}. Both views return the old value ANDed with `m_deleg` and {1,5,9}.
- R7: The hypervisor delegation register is held inside the block and makes no storage request. Only bits {2,6,10} can be written, and a read returns only those bits.
- R8: Hypervisor virtual pending view: the request goes to the pending array with a write mask limited to {2,6,10}. It returns the old value ANDed with {2,6,10}.
- R9: Hypervisor enable view: the request goes to the enable array with a write mask limited to {2,6,10,12}. It returns the old value ANDed with that same set.
- R10: High-half form (`req_high`=1): bits 31:0 of the data and of the mask are placed at 63:32 before the view rules apply. The response carries bits 63:32 of the view result in bits 31:0, and its upper half is zero.
- R11: A supervisor high-half access needs `hart32` and `aia_en`. A guest or hypervisor high-half access needs `hyp_ok`, `hart32` and `aia_en`. Guest and hypervisor low-half accesses need `hyp_ok`. The hypervisor enable view has no high-half form. An access that breaks these rules forwards no request, leaves the delegation register unchanged and responds with `rsp_illegal`=1 and `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_view | input | 3 | View code (see R2) |
| req_high | input | 1 | High-half form of the access |
| req_wdata | input | 64 | Write data in view numbering |
| req_wmask | input | 64 | Write mask in view numbering (zero for a pure read) |
| virt_mode | input | 1 | Hart runs a guest |
| hart32 | input | 1 | Hart runs with 32-bit register width |
| aia_en | input | 1 | Extended interrupt feature is present |
| hyp_ok | input | 1 | Hypervisor-level CSR access is permitted |
| m_deleg | input | 64 | Machine delegation register |
| m_req | output | 1 | Request to the machine storage |
| m_sel | output | 1 | 0 enable array, 1 pending array |
| m_wdata | output | 64 | Remapped write data |
| m_wmask | output | 64 | Filtered write mask |
| m_rdata | input | 64 | Old array value returned by the storage in the same cycle |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_illegal | output | 1 | Access refused as illegal instruction |
| rsp_rdata | output | 64 | Old value in view numbering |

## Verification
The bench feeds a chosen old value on `m_rdata` and sets the delegation register to full, partial and cleared patterns. This shows whether the guest views lift bits into the guest slots and drop them back down. A design with the shift missing or pointing the wrong way, or with the delegation filter skipped on read, returns the wrong bits. The redirect under virtualization mode is checked against the extra machine-delegation filter on its result, and the pending views are checked for their narrower write masks. A leaky pending mask would let software set timer or external pending bits. High-half accesses are checked both for the 32-bit move of the forwarded data and for the move of the result, and a design that skips the result move returns low-half bits. Each legality rule is broken on its own, including the missing high form of the hypervisor enable view. A later read of the delegation register then shows that a refused or high-half write did not change it.

// File: rtl/vsi_pkg.sv
package vsi_pkg;

  localparam int unsigned DW   = 64;
  localparam int unsigned HW   = DW / 2;
  localparam int unsigned VW   = 3;

  typedef enum logic [VW-1:0] {
    VIEW_S_IE    = 3'd0,
    VIEW_S_IP    = 3'd1,
    VIEW_VS_IE   = 3'd2,
    VIEW_VS_IP   = 3'd3,
    VIEW_H_DELEG = 3'd4,
    VIEW_H_VIP   = 3'd5,
    VIEW_H_IE    = 3'd6
  } view_e;

  localparam logic SEL_EN = 1'b0;
  localparam logic SEL_PD = 1'b1;

  // Interrupt sets in machine bit numbering.
  localparam logic [DW-1:0] SUP_SET   = 64'h0000_0000_0000_0222;
  localparam logic [DW-1:0] GST_SET   = 64'h0000_0000_0000_0444;
  localparam logic [DW-1:0] HYP_SET   = 64'h0000_0000_0000_1444;
  localparam logic [DW-1:0] SUP_PD_WR = 64'h0000_0000_0000_0002;
  localparam logic [DW-1:0] GST_PD_WR = 64'h0000_0000_0000_0004;
  localparam logic [DW-1:0] HYP_PD_WR = 64'h0000_0000_0000_0444;

  // Guest numbering to machine numbering: supervisor slots move up one.
  function automatic logic [DW-1:0] lift_sup(input logic [DW-1:0] x);
    return (x & ~SUP_SET) | ((x & SUP_SET) << 1);
  endfunction

  // Machine numbering to guest numbering: guest slots move down one.
  function automatic logic [DW-1:0] drop_gst(input logic [DW-1:0] x);
    return (x & ~GST_SET) | ((x & GST_SET) >> 1);
  endfunction

endpackage

// File: rtl/vsi_legal_check.sv
module vsi_legal_check
  import vsi_pkg::*;
(
  input  logic [VW-1:0] view,
  input  logic          high,
  input  logic          hart32,
  input  logic          aia_en,
  input  logic          hyp_ok,
  output logic          legal
);

  logic is_sup;
  logic is_hyp_side;
  logic high_ok;
  logic known;

  always_comb begin
    is_sup      = (view == VIEW_S_IE) || (view == VIEW_S_IP);
    known       = (view <= VIEW_H_IE);
    is_hyp_side = known && !is_sup;
    high_ok     = hart32 && aia_en && (view != VIEW_H_IE);
    legal       = known;
    if (is_hyp_side && !hyp_ok) legal = 1'b0;
    if (high && !high_ok)       legal = 1'b0;
  end

endmodule

// File: rtl/vsi_hdeleg_reg.sv
module vsi_hdeleg_reg
  import vsi_pkg::*;
#(
  parameter logic [DW-1:0] KEEP = GST_SET
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] wmask,
  output logic [DW-1:0] q
);

  logic [DW-1:0] eff_mask;

  always_comb eff_mask = wmask & KEEP;

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= (q & ~eff_mask) | (wdata & eff_mask);
  end

  // R7
  stored_gst_only_chk: assert property (@(posedge clk) disable iff (rst)
    (q & ~KEEP) == '0);

endmodule

// File: rtl/vsi_remap.sv
module vsi_remap
  import vsi_pkg::*;
(
  input  logic [VW-1:0] view,
  input  logic          high,
  input  logic          virt,
  input  logic [DW-1:0] hdeleg,
  input  logic [DW-1:0] mdeleg,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] wmask,
  input  logic [DW-1:0] old_val,
  output logic          use_store,
  output logic          sel,
  output logic [DW-1:0] fwd_wdata,
  output logic [DW-1:0] fwd_wmask,
  output logic [DW-1:0] hd_wmask,
  output logic [DW-1:0] ret_val
);

  logic [DW-1:0] d64, m64, dl, ml;
  logic [DW-1:0] gie_set, gip_set, sup_rd;
  logic [DW-1:0] res;
  logic          gst_path, gst_pend;

  always_comb begin
    d64     = high ? {wdata[HW-1:0], {HW{1'b0}}} : wdata;
    m64     = high ? {wmask[HW-1:0], {HW{1'b0}}} : wmask;
    dl      = lift_sup(d64);
    ml      = lift_sup(m64);
    gie_set = hdeleg & GST_SET;
    gip_set = hdeleg & GST_PD_WR;
    sup_rd  = mdeleg & SUP_SET;

    use_store = 1'b1;
    sel       = SEL_EN;
    fwd_wdata = d64;
    fwd_wmask = '0;
    hd_wmask  = '0;
    res       = '0;
    gst_path  = 1'b0;
    gst_pend  = 1'b0;

    unique case (view_e'(view))
      VIEW_S_IE: begin
        if (virt) gst_path = 1'b1;
        else begin
          fwd_wmask = m64 & sup_rd;
          res       = old_val & sup_rd;
        end
      end
      VIEW_S_IP: begin
        sel = SEL_PD;
        if (virt) begin
          gst_path = 1'b1;
          gst_pend = 1'b1;
        end else begin
          fwd_wmask = m64 & mdeleg & SUP_PD_WR;
          res       = old_val & sup_rd;
        end
      end
      VIEW_VS_IE: gst_path = 1'b1;
      VIEW_VS_IP: begin
        sel      = SEL_PD;
        gst_path = 1'b1;
        gst_pend = 1'b1;
      end
      VIEW_H_DELEG: begin
        use_store = 1'b0;
        hd_wmask  = m64 & GST_SET;
        res       = hdeleg & GST_SET;
      end
      VIEW_H_VIP: begin
        sel       = SEL_PD;
        fwd_wmask = m64 & HYP_PD_WR;
        res       = old_val & GST_SET;
      end
      VIEW_H_IE: begin
        fwd_wmask = m64 & HYP_SET;
        res       = old_val & HYP_SET;
      end
      default: use_store = 1'b0;
    endcase

    if (gst_path) begin
      fwd_wdata = dl;
      if (gst_pend) begin
        fwd_wmask = ml & gip_set;
        res       = drop_gst(old_val & gip_set);
      end else begin
        fwd_wmask = ml & gie_set;
        res       = drop_gst(old_val & gie_set);
      end
      if (view == VIEW_S_IE || view == VIEW_S_IP) res = res & sup_rd;
    end

    ret_val = high ? {{HW{1'b0}}, res[DW-1:HW]} : res;
  end

endmodule

// File: rtl/vsi_intr_view.sv
module vsi_intr_view
  import vsi_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_view,
  input  logic          req_high,
  input  logic [63:0]   req_wdata,
  input  logic [63:0]   req_wmask,
  input  logic          virt_mode,
  input  logic          hart32,
  input  logic          aia_en,
  input  logic          hyp_ok,
  input  logic [63:0]   m_deleg,
  output logic          m_req,
  output logic          m_sel,
  output logic [63:0]   m_wdata,
  output logic [63:0]   m_wmask,
  input  logic [63:0]   m_rdata,
  output logic          rsp_valid,
  output logic          rsp_illegal,
  output logic [63:0]   rsp_rdata
);

  logic          legal;
  logic          accept;
  logic          use_store;
  logic          sel_c;
  logic [DW-1:0] fwd_wdata, fwd_wmask, hd_wmask, ret_val, hdeleg_q;
  logic          hd_we;

  vsi_legal_check u_legal (
    .view   (req_view),
    .high   (req_high),
    .hart32 (hart32),
    .aia_en (aia_en),
    .hyp_ok (hyp_ok),
    .legal  (legal)
  );

  vsi_remap u_remap (
    .view      (req_view),
    .high      (req_high),
    .virt      (virt_mode),
    .hdeleg    (hdeleg_q),
    .mdeleg    (m_deleg),
    .wdata     (req_wdata),
    .wmask     (req_wmask),
    .old_val   (m_rdata),
    .use_store (use_store),
    .sel       (sel_c),
    .fwd_wdata (fwd_wdata),
    .fwd_wmask (fwd_wmask),
    .hd_wmask  (hd_wmask),
    .ret_val   (ret_val)
  );

  always_comb begin
    accept  = req_valid && legal;
    hd_we   = accept && (req_view == VIEW_H_DELEG);
    m_req   = accept && use_store;
    m_sel   = m_req ? sel_c : 1'b0;
    m_wdata = m_req ? fwd_wdata : '0;
    m_wmask = m_req ? fwd_wmask : '0;
  end

  vsi_hdeleg_reg #(.KEEP(GST_SET)) u_hdeleg (
    .clk   (clk),
    .rst   (rst),
    .we    (hd_we),
    .wdata (req_high ? {req_wdata[HW-1:0], {HW{1'b0}}} : req_wdata),
    .wmask (hd_wmask),
    .q     (hdeleg_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_illegal <= req_valid && !legal;
      rsp_rdata   <= accept ? ret_val : '0;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !rsp_illegal && rsp_rdata == '0));

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R11
  illegal_no_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_illegal |-> ($past(!m_req) && rsp_rdata == '0));

  // R3
  gst_ie_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && req_view == VIEW_VS_IE) |-> (m_wmask & ~(hdeleg_q & GST_SET)) == '0);

  // R9
  hyp_ie_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && req_view == VIEW_H_IE) |-> (m_wmask & ~HYP_SET) == '0);

  // R8
  hyp_vip_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (m_req && req_view == VIEW_H_VIP) |-> (m_sel && (m_wmask & ~HYP_PD_WR) == '0));

endmodule

// File: tb/tb_vsi_intr_view.sv
`timescale 1ns/1ps
module tb_vsi_intr_view;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [2:0]  req_view;
  logic        req_high;
  logic [63:0] req_wdata, req_wmask;
  logic        virt_mode, hart32, aia_en, hyp_ok;
  logic [63:0] m_deleg;
  logic        m_req, m_sel;
  logic [63:0] m_wdata, m_wmask, m_rdata;
  logic        rsp_valid, rsp_illegal;
  logic [63:0] rsp_rdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  vsi_intr_view dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_view(req_view),
    .req_high(req_high), .req_wdata(req_wdata), .req_wmask(req_wmask),
    .virt_mode(virt_mode), .hart32(hart32), .aia_en(aia_en), .hyp_ok(hyp_ok),
    .m_deleg(m_deleg), .m_req(m_req), .m_sel(m_sel), .m_wdata(m_wdata),
    .m_wmask(m_wmask), .m_rdata(m_rdata), .rsp_valid(rsp_valid),
    .rsp_illegal(rsp_illegal), .rsp_rdata(rsp_rdata)
  );

  typedef struct packed {
    logic [7:0]  tag;
    logic [2:0]  view;
    logic        high, virt, h32, aia, hyp;
    logic [63:0] mdel, wd, wm, mrd;
    logic        mreq, sel;
    logic [63:0] ewm, ewd;
    logic        eill;
    logic [63:0] erd;
  } vec_t;

  localparam logic [63:0] ONES = '1;
  localparam int NV = 23;

  localparam vec_t VECS [0:NV-1] = '{
    // R7 write delegation, old value zero after reset (R1)
    '{8'd7, 3'd4, 1'b0,1'b0,1'b0,1'b0,1'b1, 64'h0, 64'hFFFF, 64'hFFFF, 64'h0, 1'b0,1'b0, 64'h0, 64'h0, 1'b0, 64'h0},
    // R7 read back only guest bits
    '{8'd7, 3'd4, 1'b0,1'b0,1'b0,1'b0,1'b1, 64'h0, 64'h0, 64'h0, 64'h0, 1'b0,1'b0, 64'h0, 64'h0, 1'b0, 64'h444},
    // R3 guest enable, full delegation
    '{8'd3, 3'd2, 1'b0,1'b0,1'b0,1'b0,1'b1, 64'h0, 64'h222, 64'h222, 64'h1FFF, 1'b1,1'b0, 64'h444, 64'h444, 1'b0, 64'h222},
    // R7 narrow delegation to bit 6
    '{8'd7, 3'd4, 1'b0,1'b0,1'b0,1'b0,1'b1, 64'h0, 64'h040, 64'h444, 64'h0, 1'b0,1'b0, 64'h0, 64'h0, 1'b0, 64'h444},
    // R3 guest enable, partial delegation
    '{8'd3, 3'd2, 1'b0,1'b0,1'b0,1'b0,1'b1, 64'h0, 64'h222, 64'h222, 64'h444, 1'b1,1'b0, 64'h040, 64'h444, 1'b0, 64'h020},
    // R7 restore full delegation
    '{8'd7, 3'd4, 1'b0,1'b0,1'b0,1'b0,1'b1, 64'h0, 64'h444, 64'h444, 64'h0, 1'b0,1'b0, 64'h0, 64'h0, 1'b0, 64'h040},
    // R4 guest pending
    '{8'd4, 3'd3, 1'b0,1'b0,1'b0,1'b0,1'b1, 64'h0, 64'h002, 64'h222, 64'h444, 1'b1,1'b1, 64'h004, 64'h004, 1'b0, 64'h002},
    // R5 supervisor enable redirected
    '{8'd5, 3'd0, 1'b0,1'b1,1'b0,1'b0,1'b1, 64'h020, 64'h222, 64'h222, 64'h444, 1'b1,1'b0, 64'h444, 64'h444, 1'b0, 64'h020},
    // R5 supervisor pending redirected
    '{8'd5, 3'd1, 1'b0,1'b1,1'b0,1'b0,1'b1, 64'h222, 64'h0, 64'h002, 64'h004, 1'b1,1'b1, 64'h004, 64'h0, 1'b0, 64'h002},
    // R6 supervisor enable direct
    '{8'd6, 3'd0, 1'b0,1'b0,1'b0,1'b0,1'b1, 64'h022, 64'hFFF, 64'hFFF, 64'hFFF, 1'b1,1'b0, 64'h022, 64'hFFF, 1'b0, 64'h022},
    // R6 supervisor pending direct
    '{8'd6, 3'd1, 1'b0,1'b0,1'b0,1'b0,1'b1, 64'h222, 64'h222, 64'h222, 64'h666, 1'b1,1'b1, 64'h002, 64'h222, 1'b0, 64'h222},
    // R8 hypervisor virtual pending
    '{8'd8, 3'd5, 1'b0,1'b0,1'b0,1'b0,1'b1, 64'h0, 64'hFFFF, 64'hFFFF, 64'hFFFF, 1'b1,1'b1, 64'h444, 64'hFFFF, 1'b0, 64'h444},
    // R9 hypervisor enable
    '{8'd9, 3'd6, 1'b0,1'b0,1'b0,1'b0,1'b1, 64'h0, 64'h0, 64'hFFFF, 64'hFFFF, 1'b1,1'b0, 64'h1444, 64'h0, 1'b0, 64'h1444},
    // R10 supervisor enable high half
    '{8'd10, 3'd0, 1'b1,1'b0,1'b1,1'b1,1'b1, ONES, 64'h1234_5678, 64'hFFFF_FFFF, 64'h222, 1'b1,1'b0, 64'h0, 64'h1234_5678_0000_0000, 1'b0, 64'h0},
    // R10 guest enable high half
    '{8'd10, 3'd2, 1'b1,1'b0,1'b1,1'b1,1'b1, 64'h0, 64'h222, 64'h222, ONES, 1'b1,1'b0, 64'h0, 64'h0000_0222_0000_0000, 1'b0, 64'h0},
    // R11 supervisor high on a 64-bit hart
    '{8'd11, 3'd0, 1'b1,1'b0,1'b0,1'b1,1'b1, ONES, 64'h1, 64'h1, ONES, 1'b0,1'b0, 64'h0, 64'h0, 1'b1, 64'h0},
    // R11 supervisor high without feature
    '{8'd11, 3'd0, 1'b1,1'b0,1'b1,1'b0,1'b1, ONES, 64'h1, 64'h1, ONES, 1'b0,1'b0, 64'h0, 64'h0, 1'b1, 64'h0},
    // R11 guest high without hypervisor access
    '{8'd11, 3'd2, 1'b1,1'b0,1'b1,1'b1,1'b0, 64'h0, 64'h1, 64'h1, ONES, 1'b0,1'b0, 64'h0, 64'h0, 1'b1, 64'h0},
    // R11 hypervisor enable has no high form
    '{8'd11, 3'd6, 1'b1,1'b0,1'b1,1'b1,1'b1, 64'h0, 64'h1, 64'h1, ONES, 1'b0,1'b0, 64'h0, 64'h0, 1'b1, 64'h0},
    // R11 delegation write without hypervisor access
    '{8'd11, 3'd4, 1'b0,1'b0,1'b0,1'b0,1'b0, 64'h0, 64'h0, 64'h444, 64'h0, 1'b0,1'b0, 64'h0, 64'h0, 1'b1, 64'h0},
    // R11 delegation unchanged by refused write
    '{8'd7, 3'd4, 1'b0,1'b0,1'b0,1'b0,1'b1, 64'h0, 64'h0, 64'h0, 64'h0, 1'b0,1'b0, 64'h0, 64'h0, 1'b0, 64'h444},
    // R10 delegation high half write of zeros
    '{8'd10, 3'd4, 1'b1,1'b0,1'b1,1'b1,1'b1, 64'h0, 64'h0, 64'hFFFF_FFFF, 64'h0, 1'b0,1'b0, 64'h0, 64'h0, 1'b0, 64'h0},
    // R10 low bits untouched by high write
    '{8'd7, 3'd4, 1'b0,1'b0,1'b0,1'b0,1'b1, 64'h0, 64'h0, 64'h0, 64'h0, 1'b0,1'b0, 64'h0, 64'h0, 1'b0, 64'h444}
  };

  task automatic check(input int tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 1'b0; req_view = '0; req_high = 1'b0;
    req_wdata = '0; req_wmask = '0; virt_mode = 1'b0;
    hart32 = 1'b0; aia_en = 1'b0; hyp_ok = 1'b0;
    m_deleg = '0; m_rdata = '0;
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    req_valid = 1'b1; req_view = v.view; req_high = v.high;
    req_wdata = v.wd; req_wmask = v.wm; virt_mode = v.virt;
    hart32 = v.h32; aia_en = v.aia; hyp_ok = v.hyp;
    m_deleg = v.mdel; m_rdata = v.mrd;
    #1;
    check(v.tag, "m_req", {63'd0, m_req}, {63'd0, v.mreq});
    if (v.mreq) begin
      check(v.tag, "m_sel", {63'd0, m_sel}, {63'd0, v.sel});
      check(v.tag, "m_wmask", m_wmask, v.ewm);
      check(v.tag, "m_wdata", m_wdata, v.ewd);
    end
    @(negedge clk);
    check(v.tag, "rsp_illegal", {63'd0, rsp_illegal}, {63'd0, v.eill});
    check(v.tag, "rsp_rdata", rsp_rdata, v.erd);
    idle_inputs();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL R2 watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(1, "rsp_valid", {63'd0, rsp_valid}, 64'd0);
    check(1, "rsp_illegal", {63'd0, rsp_illegal}, 64'd0);
    check(1, "rsp_rdata", rsp_rdata, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R2 response strobe timing
    @(negedge clk);
    req_valid = 1'b1; req_view = 3'd6; hyp_ok = 1'b1;
    @(negedge clk);
    check(2, "rsp_valid after request", {63'd0, rsp_valid}, 64'd1);
    req_valid = 1'b0;
    @(negedge clk);
    check(2, "rsp_valid after idle", {63'd0, rsp_valid}, 64'd0);

    // R1 reset mid-run clears the delegation register
    rst = 1'b1;
    @(negedge clk);
    check(1, "rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
    rst = 1'b0;
    run_vec('{8'd1, 3'd4, 1'b0,1'b0,1'b0,1'b0,1'b1, 64'h0, 64'h0, 64'h0, 64'h0,
              1'b0,1'b0, 64'h0, 64'h0, 1'b0, 64'h0});

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule